// File: doc/BRIEF.md
# EPP Host Cycle Controller

This block is the host end of an enhanced parallel port. A simple host register interface reaches one address port and four equivalent data ports through a three-bit offset. Each accepted access runs one handshake on an 8-bit parallel bus. Address-port accesses pulse the address strobe, and data-port accesses pulse the data strobe. The block drives the direction line and the outgoing byte. It waits for the peripheral's wait line to rise, captures read data as the strobe releases, and then reports completion to the host. Until that point, the host is held off with a wait signal.

A cycle counter guards every handshake. If the peripheral never answers, the counter aborts the cycle and sets a sticky timeout flag. The flag stays set until the host clears it. Two control-port bits can change the direction of a cycle. The printer-strobe control bit forces any cycle into write mode. The direction bit turns an attempted write into a read, and no error is raised. Between cycles, the bus direction and the strobe, autofeed and init pins simply follow the control-port bits.

Top module: `epp_host_port`

## Requirements
- R1: An accepted access at offset 3 runs an address cycle: `nAddrStb` is driven low and `nDataStb` stays high for that cycle.
- R2: An accepted access at offsets 4, 5, 6 or 7 runs a data cycle on `nDataStb`, with `nAddrStb` high. All four offsets behave alike.
- R3: During a write cycle, the host byte appears unchanged on `pdOut` with `pdOe` high and `nWrite` low. The byte stays stable while the strobe is low.
- R4: During a read cycle, `nWrite` stays high and `pdOe` stays low. The value on `pdIn` is captured at the clock edge where the strobe rises, and it is presented on `hostRdata` when `hostDone` pulses.
- R5: Reset clears the outgoing data register (`pdOut` = 0) and the timeout flag. It also leaves both strobes and `nWrite` high and `hostWait` low.
- R6: `hostWait` is high from the clock after an accepted request, through the strobe phase, until completion. Completion is a one-cycle `hostDone` pulse.
- R7: If `nWait` has not risen within TMO_CYC clocks of the cycle start, the cycle is aborted. The strobe is released, `hostDone` pulses, and `statTimeout` rises. The flag stays set until `statClr` is pulsed.
- R8: While `ctlStrobe` is 1, any running cycle has `nWrite` low and `pdOe` high, even a read.
- R9: A write attempted with `ctlDir` = 1 runs as a read cycle, with `nWrite` high and `pdIn` captured. The data register keeps its old value, and `statTimeout` is not set.
- R10: When no cycle is running, `pdOe` = !`ctlDir`, `nStrobe` = !`ctlStrobe`, `nAutofd` = !`ctlAutofd` and `nInit` = !`ctlInit`.
- R11: A request is ignored when `eppEn` is 0 or the offset is 0, 1 or 2. In that case no strobe falls and `hostWait` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eppEn | input | 1 | Enables EPP cycles |
| hostReq | input | 1 | One-cycle access request, taken only when idle |
| hostWr | input | 1 | 1 = write access, 0 = read access |
| hostAddr | input | 3 | Register offset (3 = address port, 4..7 = data ports) |
| hostWdata | input | 8 | Write byte |
| hostRdata | output | 8 | Byte captured by the last read cycle |
| hostWait | output | 1 | Wait state for the host access |
| hostDone | output | 1 | One-cycle completion (or abort) pulse |
| ctlDir | input | 1 | Control-port direction bit (1 = input) |
| ctlStrobe | input | 1 | Control-port strobe bit |
| ctlAutofd | input | 1 | Control-port autofeed bit |
| ctlInit | input | 1 | Control-port init bit |
| statClr | input | 1 | Clears the timeout flag |
| statTimeout | output | 1 | Sticky timeout flag (status bit 0) |
| pdOut | output | 8 | Parallel bus output byte |
| pdIn | input | 8 | Parallel bus input byte |
| pdOe | output | 1 | Parallel bus output enable |
| nWrite | output | 1 | Cycle direction, low = write |
| nAddrStb | output | 1 | Address strobe, active low |
| nDataStb | output | 1 | Data strobe, active low |
| nWait | input | 1 | Peripheral handshake; high acknowledges the strobe |
| nStrobe | output | 1 | Printer strobe pin |
| nAutofd | output | 1 | Autofeed pin |
| nInit | output | 1 | Init pin |

## Verification
A wrong state in the sequencer shows up at once on the strobe pins. A strobe may fall on the wrong line, or it may fall without `hostWait` being high. In either case the scoreboard flags it at the strobe edge, one clock after the request. A wrong latched direction shows up in `nWrite` and `pdOe` during the same strobe phase. A bad capture, a lost data register or a timer that runs too long or too short shows up only when `hostDone` pulses. That pulse comes a few clocks later in a normal cycle, and about TMO_CYC clocks later in an aborted one.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] ADDR_PORT = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_RELEASE, ST_DONE, ST_ABORT
  } eppState_e;

  typedef struct packed {
    logic loadOut;    // latch host byte into the outgoing register
    logic captureIn;  // sample the bus into the read register
    logic busActive;  // an EPP cycle owns the bus
    logic driveBus;   // drive the bus during the cycle
  } eppCtl_t;
endpackage

// File: rtl/epp_ctrl.sv
module epp_ctrl
  import epp_pkg::*;
#(
  parameter int TMO_CYC = 500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eppEn,
  input  logic             hostReq,
  input  logic             hostWr,
  input  logic [OFS_W-1:0] hostAddr,
  input  logic             ctlDir,
  input  logic             ctlStrobe,
  input  logic             nWait,
  input  logic             statClr,
  output eppCtl_t          ctl,
  output logic             hostWait,
  output logic             hostDone,
  output logic             nAddrStb,
  output logic             nDataStb,
  output logic             nWrite,
  output logic             statTimeout
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

  eppState_e state;
  logic cycAddr, cycWrite;
  logic [CNT_W-1:0] cnt;
  logic start, ack, expired;

  assign start   = (state == ST_IDLE) && hostReq && eppEn && (hostAddr >= ADDR_PORT);
  assign ack     = (state == ST_STROBE) && nWait;
  assign expired = (state == ST_STROBE) && !nWait && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cycAddr     <= 1'b0;
      cycWrite    <= 1'b0;
      cnt         <= '0;
      statTimeout <= 1'b0;
    end else begin
      if (expired)      statTimeout <= 1'b1;
      else if (statClr) statTimeout <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SETUP;
          cycAddr  <= (hostAddr == ADDR_PORT);
          cycWrite <= hostWr && !ctlDir;
          cnt      <= '0;
        end
        ST_SETUP: begin
          state <= ST_STROBE;
          cnt   <= cnt + 1'b1;
        end
        ST_STROBE: begin
          if (ack)          state <= ST_RELEASE;
          else if (expired) state <= ST_ABORT;
          else              cnt   <= cnt + 1'b1;
        end
        ST_RELEASE: state <= ST_DONE;
        ST_DONE:    state <= ST_IDLE;
        ST_ABORT:   state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign hostWait = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_RELEASE);
  assign hostDone = (state == ST_DONE) || (state == ST_ABORT);
  assign nAddrStb = !((state == ST_STROBE) && cycAddr);
  assign nDataStb = !((state == ST_STROBE) && !cycAddr);
  assign nWrite   = !(hostWait && (cycWrite || ctlStrobe));

  always_comb begin
    ctl.loadOut   = start && hostWr && !ctlDir;
    ctl.captureIn = ack && !cycWrite;
    ctl.busActive = hostWait;
    ctl.driveBus  = cycWrite || ctlStrobe;
  end
endmodule

// File: rtl/epp_dpath.sv
module epp_dpath
  import epp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eppCtl_t           ctl,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] pdIn,
  input  logic              ctlDir,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] pdOut,
  output logic              pdOe
);
  logic [DATA_W-1:0] outReg, inReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      inReg  <= '0;
    end else begin
      if (ctl.loadOut)   outReg <= hostWdata;
      if (ctl.captureIn) inReg  <= pdIn;
    end
  end

  assign pdOut     = outReg;
  assign hostRdata = inReg;
  assign pdOe      = ctl.busActive ? ctl.driveBus : !ctlDir;
endmodule

// File: rtl/epp_host_port.sv
module epp_host_port
  import epp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TMO_CYC = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eppEn,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [2:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostWait,
  output logic              hostDone,
  input  logic              ctlDir,
  input  logic              ctlStrobe,
  input  logic              ctlAutofd,
  input  logic              ctlInit,
  input  logic              statClr,
  output logic              statTimeout,
  output logic [DATA_W-1:0] pdOut,
  input  logic [DATA_W-1:0] pdIn,
  output logic              pdOe,
  output logic              nWrite,
  output logic              nAddrStb,
  output logic              nDataStb,
  input  logic              nWait,
  output logic              nStrobe,
  output logic              nAutofd,
  output logic              nInit
);
  eppCtl_t ctl;

  epp_ctrl #(.TMO_CYC(TMO_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .eppEn(eppEn), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .ctlDir(ctlDir), .ctlStrobe(ctlStrobe), .nWait(nWait),
    .statClr(statClr), .ctl(ctl), .hostWait(hostWait), .hostDone(hostDone),
    .nAddrStb(nAddrStb), .nDataStb(nDataStb), .nWrite(nWrite),
    .statTimeout(statTimeout)
  );

  epp_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostWdata(hostWdata), .pdIn(pdIn),
    .ctlDir(ctlDir), .hostRdata(hostRdata), .pdOut(pdOut), .pdOe(pdOe)
  );

  assign nStrobe = !ctlStrobe;
  assign nAutofd = !ctlAutofd;
  assign nInit   = !ctlInit;
endmodule

// File: rtl/epp_host_port_chk.sv
module epp_host_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWait,
  input logic              hostDone,
  input logic              ctlDir,
  input logic              ctlStrobe,
  input logic              statClr,
  input logic              statTimeout,
  input logic [DATA_W-1:0] pdOut,
  input logic              pdOe,
  input logic              nWrite,
  input logic              nAddrStb,
  input logic              nDataStb
);
  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!nAddrStb && !nDataStb));
  // R6
  wait_in_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!nAddrStb || !nDataStb) |-> hostWait);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);
  // R3
  write_byte_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!nWrite && (!nAddrStb || !nDataStb)) |=> ((nAddrStb && nDataStb) || $stable(pdOut)));
  // R7
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statTimeout && !statClr) |=> statTimeout);
  // R8
  force_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrobe && (!nAddrStb || !nDataStb)) |-> (!nWrite && pdOe));
  // R10
  idle_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostWait |-> (pdOe == !ctlDir));
endmodule

bind epp_host_port epp_host_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWait(hostWait), .hostDone(hostDone),
  .ctlDir(ctlDir), .ctlStrobe(ctlStrobe), .statClr(statClr),
  .statTimeout(statTimeout), .pdOut(pdOut), .pdOe(pdOe), .nWrite(nWrite),
  .nAddrStb(nAddrStb), .nDataStb(nDataStb)
);

// File: tb/epp_host_port_bench.sv
module epp_host_port_bench;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eppEn = 1'b1, hostReq = 1'b0, hostWr = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWdata = '0, hostRdata, pdOut, pdIn;
  logic hostWait, hostDone, statTimeout, pdOe, nWrite, nAddrStb, nDataStb;
  logic nWait = 1'b0, nStrobe, nAutofd, nInit;
  logic ctlDir = 1'b0, ctlStrobe = 1'b0, ctlAutofd = 1'b0, ctlInit = 1'b0, statClr = 1'b0;

  int checks = 0, fails = 0;
  logic stall = 1'b0;
  logic [7:0] periphByte = '0;

  typedef struct packed {
    logic isAddr;
    logic busWr;
    logic [7:0] wByte;
    logic chkRd;
    logic [7:0] rByte;
    logic tmo;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  epp_host_port #(.DATA_W(8), .TMO_CYC(TMO)) u_epp_host_port (
    .clk(clk), .rstN(rstN), .eppEn(eppEn), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostWait(hostWait), .hostDone(hostDone), .ctlDir(ctlDir), .ctlStrobe(ctlStrobe),
    .ctlAutofd(ctlAutofd), .ctlInit(ctlInit), .statClr(statClr),
    .statTimeout(statTimeout), .pdOut(pdOut), .pdIn(pdIn), .pdOe(pdOe),
    .nWrite(nWrite), .nAddrStb(nAddrStb), .nDataStb(nDataStb), .nWait(nWait),
    .nStrobe(nStrobe), .nAutofd(nAutofd), .nInit(nInit)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // peripheral: acknowledge a low strobe after two sampled clocks unless stalled
  initial begin
    int held = 0;
    forever begin
      @(negedge clk);
      pdIn = periphByte;
      if (!nAddrStb || !nDataStb) begin
        held++;
        if (held >= 2 && !stall) nWait = 1'b1;
      end else begin
        held = 0;
        nWait = 1'b0;
      end
    end
  end

  // monitor: record the strobe phase, compare against the queue on completion
  initial begin
    logic prevStb = 1'b0;
    logic obsAddr = 1'b0, obsWr = 1'b0, obsOe = 1'b0, obsWait = 1'b0;
    logic [7:0] obsByte = '0;
    expItem_t e;
    forever begin
      @(negedge clk);
      if ((!nAddrStb || !nDataStb) && !prevStb) begin
        obsAddr = !nAddrStb;
        obsWr = !nWrite;
        obsOe = pdOe;
        obsByte = pdOut;
        obsWait = hostWait;
      end else if ((!nAddrStb || !nDataStb) && !nWrite) begin
        check("R3 byte held during strobe", pdOut, obsByte);
      end
      prevStb = !nAddrStb || !nDataStb;
      if (hostDone && rstN) begin
        if (expQ.size() == 0) begin
          check("R6 unexpected completion", 8'd1, 8'd0);
        end else begin
          e = expQ.pop_front();
          check("R1 R2 strobe kind", {7'd0, obsAddr}, {7'd0, e.isAddr});
          check("R6 wait high in strobe", {7'd0, obsWait}, 8'd1);
          check("R7 timeout flag", {7'd0, statTimeout}, {7'd0, e.tmo});
          check("R8 R9 nWrite low", {7'd0, obsWr}, {7'd0, e.busWr});
          check("R4 R8 R9 bus enable", {7'd0, obsOe}, {7'd0, e.busWr});
          if (e.busWr) check("R3 bus byte", obsByte, e.wByte);
          if (e.chkRd) check("R4 read byte", hostRdata, e.rByte);
        end
      end
    end
  end

  task automatic access(input logic wr, input logic [2:0] ofs, input logic [7:0] wb,
                        input logic [7:0] pb, input expItem_t e);
    expQ.push_back(e);
    periphByte = pb;
    @(posedge clk); #2;
    hostReq = 1'b1; hostWr = wr; hostAddr = ofs; hostWdata = wb;
    @(posedge clk); #2;
    hostReq = 1'b0;
    while (!hostDone) begin @(posedge clk); #2; end
    @(posedge clk); #2;
  endtask

  task automatic ignoredReq(input logic [2:0] ofs, input string tag);
    logic sawWait = 1'b0, sawStb = 1'b0;
    @(posedge clk); #2;
    hostReq = 1'b1; hostWr = 1'b1; hostAddr = ofs; hostWdata = 8'hEE;
    @(posedge clk); #2;
    hostReq = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (hostWait) sawWait = 1'b1;
      if (!nAddrStb || !nDataStb) sawStb = 1'b1;
    end
    check({tag, " no wait"}, {7'd0, sawWait}, 8'd0);
    check({tag, " no strobe"}, {7'd0, sawStb}, 8'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R5 data reg cleared", pdOut, 8'h00);
    check("R5 timeout clear", {7'd0, statTimeout}, 8'd0);
    check("R5 strobes idle", {6'd0, nAddrStb, nDataStb}, 8'd3);
    check("R5 nWrite idle", {7'd0, nWrite}, 8'd1);
    check("R5 no wait", {7'd0, hostWait}, 8'd0);
    check("R10 idle drive", {7'd0, pdOe}, 8'd1);

    // R1 address write, R3 byte on bus
    access(1'b1, 3'd3, 8'h5A, 8'h00, '{isAddr:1'b1, busWr:1'b1, wByte:8'h5A, chkRd:1'b0, rByte:8'h00, tmo:1'b0});
    check("R3 byte kept after write", pdOut, 8'h5A);
    // R2 all four data ports
    for (int i = 4; i < 8; i++)
      access(1'b1, 3'(i), 8'(8'h10 * i + 3), 8'h00,
             '{isAddr:1'b0, busWr:1'b1, wByte:8'(8'h10 * i + 3), chkRd:1'b0, rByte:8'h00, tmo:1'b0});
    // R4 reads
    access(1'b0, 3'd5, 8'h00, 8'hC3, '{isAddr:1'b0, busWr:1'b0, wByte:8'h00, chkRd:1'b1, rByte:8'hC3, tmo:1'b0});
    access(1'b0, 3'd3, 8'h00, 8'h3C, '{isAddr:1'b1, busWr:1'b0, wByte:8'h00, chkRd:1'b1, rByte:8'h3C, tmo:1'b0});
    // R8 strobe bit forces write mode on a read
    ctlStrobe = 1'b1;
    access(1'b0, 3'd6, 8'h00, 8'h81, '{isAddr:1'b0, busWr:1'b1, wByte:8'h73, chkRd:1'b1, rByte:8'h81, tmo:1'b0});
    ctlStrobe = 1'b0;
    // R9 direction bit turns write into read
    ctlDir = 1'b1;
    access(1'b1, 3'd4, 8'h99, 8'h6E, '{isAddr:1'b0, busWr:1'b0, wByte:8'h00, chkRd:1'b1, rByte:8'h6E, tmo:1'b0});
    ctlDir = 1'b0;
    @(negedge clk);
    check("R9 data reg unchanged", pdOut, 8'h73);
    check("R9 no error flagged", {7'd0, statTimeout}, 8'd0);
    // R7 timeout
    stall = 1'b1;
    access(1'b1, 3'd7, 8'hA5, 8'h00, '{isAddr:1'b0, busWr:1'b1, wByte:8'hA5, chkRd:1'b0, rByte:8'h00, tmo:1'b1});
    stall = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 flag sticky", {7'd0, statTimeout}, 8'd1);
    check("R7 strobes released", {6'd0, nAddrStb, nDataStb}, 8'd3);
    @(posedge clk); #2 statClr = 1'b1;
    @(posedge clk); #2 statClr = 1'b0;
    @(negedge clk);
    check("R7 flag cleared", {7'd0, statTimeout}, 8'd0);
    // R10 idle pass-through
    ctlDir = 1'b1; ctlStrobe = 1'b1; ctlAutofd = 1'b1; ctlInit = 1'b1;
    @(negedge clk);
    check("R10 idle dir input", {7'd0, pdOe}, 8'd0);
    check("R10 strobe pin", {7'd0, nStrobe}, 8'd0);
    check("R10 autofd pin", {7'd0, nAutofd}, 8'd0);
    check("R10 init pin", {7'd0, nInit}, 8'd0);
    ctlDir = 1'b0; ctlStrobe = 1'b0; ctlAutofd = 1'b0; ctlInit = 1'b0;
    // R11 ignored requests
    eppEn = 1'b0;
    ignoredReq(3'd4, "R11 disabled");
    eppEn = 1'b1;
    ignoredReq(3'd1, "R11 low offset");
    @(negedge clk);
    check("R11 data reg untouched", pdOut, 8'hA5);
    check("R6 all items completed", 8'(expQ.size()), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule